// File: doc/BRIEF.md
# Tagged Request/Reply Memory Target

This block is the target end of a point-to-point bus that carries requests and replies as separate packets. It sits in front of a small on-chip word memory. Each request word carries an address, a write data word, a command, a 4-bit transaction tag, an end-of-packet marker and a contiguous-address flag. For every accepted request word the block returns exactly one reply word. The reply carries read data, a status code, the same tag and the same end-of-packet marker.

Each direction has its own valid/acknowledge pair, and a word moves only in a cycle where both are high. The target handles every word of a burst on its own, using the address sent with that word, so it keeps no burst sequencer. When the initiator flags a packet as contiguous, the target checks that each address is one more than the address before it. A single reply register absorbs stalls on the reply side. The request side is throttled so that no reply is ever lost.

Top module: `pkt_mem_target`

## Requirements
- R1: After synchronous reset, rsp_val is 0 and req_ack is 1.
- R2: A read (req_cmd 2'b01) to an address below DEPTH (64) returns the stored 32-bit word with status 2'b00 and the request's tag. The reply is valid in the cycle after acceptance.
- R3: A write (req_cmd 2'b10) to an address below DEPTH stores req_wdata at that word address. It replies with data 0 and status 2'b00.
- R4: A no-op (req_cmd 2'b00), or the unused code 2'b11, replies with data 0 and status 2'b00 and leaves memory unchanged.
- R5: A read or write to an address of DEPTH or more replies with status 2'b01 and data 0. Such a write changes no memory word, including the word whose index equals the low address bits.
- R6: With req_contig set on a word that follows a word with req_eop 0, an address other than the previous accepted address plus one gives status 2'b01 and data 0 for a read or write. Such a write is suppressed.
- R7: rsp_eop of each reply equals req_eop of the request word it answers.
- R8: While rsp_val is 1 and rsp_ack is 0, the reply word stays unchanged and req_ack is 0. req_ack is 1 whenever the reply register is empty or is draining.
- R9: With rsp_ack held high, one request word is accepted in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_val | input | 1 | Request word valid |
| req_ack | output | 1 | Request word accepted this cycle if req_val is high |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| req_cmd | input | 2 | 00 no-op, 01 read, 10 write, 11 treated as no-op |
| req_tag | input | 4 | Transaction tag |
| req_eop | input | 1 | Last word of the packet |
| req_contig | input | 1 | Addresses in the packet are sequential |
| rsp_val | output | 1 | Reply word valid |
| rsp_ack | input | 1 | Initiator takes the reply word |
| rsp_rdata | output | 32 | Read data, 0 for non-reads and errors |
| rsp_status | output | 2 | 00 OK, 01 address error |
| rsp_tag | output | 4 | Tag copied from the request |
| rsp_eop | output | 1 | End-of-packet copied from the request |

## Verification
A contiguous write burst fills the whole memory, and a contiguous read burst then reads part of it back. These two runs separate a correct word-by-word address path from one that ignores the per-word address or misreads the framing. Directed words then probe what should leave memory untouched: out-of-range writes that alias a valid index, a broken contiguous sequence and no-op commands. Each is followed by a readback at the port. A stall phase holds the reply acknowledge low under a steady request stream. A long random phase then mixes acknowledge gaps, commands, tags, flags and addresses around the depth boundary. Together these separate correct throttling and reply hold from designs that drop, repeat or corrupt replies.

// File: rtl/pkt_mem_pkg.sv
package pkt_mem_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_RSV = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'b00,
        ST_ADDR_ERR = 2'b01
    } status_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        status_e           status;
        logic [TAG_W-1:0]  tag;
        logic              eop;
    } reply_t;

    function automatic logic addr_in_range(input logic [ADDR_W-1:0] a, input int depth);
        return int'(a) < depth;
    endfunction

endpackage

// File: rtl/pkt_req_decode.sv
module pkt_req_decode
    import pkt_mem_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cmd,
    input  logic [TAG_W-1:0]  tag,
    input  logic              eop,
    input  logic              contig,
    input  logic [DATA_W-1:0] rdata,
    output logic              wr_en,
    output reply_t            reply
);
    logic [ADDR_W-1:0] prev_addr;
    logic              mid_packet;
    logic              seq_break;
    logic              bad_addr;
    cmd_e              op;

    assign op        = cmd_e'(cmd);
    assign seq_break = contig && mid_packet && (addr != prev_addr + ADDR_W'(1));
    assign bad_addr  = !addr_in_range(addr, DEPTH) || seq_break;

    always_comb begin
        reply.data   = '0;
        reply.status = ST_OK;
        reply.tag    = tag;
        reply.eop    = eop;
        wr_en        = 1'b0;
        unique case (op)
            CMD_RD: begin
                if (bad_addr) reply.status = ST_ADDR_ERR;
                else          reply.data   = rdata;
            end
            CMD_WR: begin
                if (bad_addr) reply.status = ST_ADDR_ERR;
                else          wr_en        = fire;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_addr  <= '0;
            mid_packet <= 1'b0;
        end else if (fire) begin
            prev_addr  <= addr;
            mid_packet <= !eop;
        end
    end

    // R4
    nop_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op == CMD_NOP || op == CMD_RSV) |-> !wr_en);
endmodule

// File: rtl/pkt_mem_array.sv
module pkt_mem_array
    import pkt_mem_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [DEPTH];

    assign rdata = words[idx];

    always_ff @(posedge clk) begin
        if (wr_en) words[idx] <= wdata;
    end
endmodule

// File: rtl/pkt_reply_skid.sv
module pkt_reply_skid
    import pkt_mem_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  reply_t din,
    input  logic   drain,
    output logic   full,
    output reply_t dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            dout <= '0;
        end else if (load) begin
            full <= 1'b1;
            dout <= din;
        end else if (full && drain) begin
            full <= 1'b0;
        end
    end

    // R8
    reply_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !drain) |=> (full && $stable(dout)));
endmodule

// File: rtl/pkt_mem_target.sv
module pkt_mem_target
    import pkt_mem_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_val,
    output logic              req_ack,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_cmd,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_eop,
    input  logic              req_contig,
    output logic              rsp_val,
    input  logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_status,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_eop
);
    logic              fire;
    logic              wr_en;
    logic              skid_full;
    logic [DATA_W-1:0] mem_rdata;
    reply_t            next_reply;
    reply_t            held_reply;

    assign req_ack = !skid_full || rsp_ack;
    assign fire    = req_val && req_ack;

    pkt_req_decode #(.DEPTH(DEPTH)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .addr   (req_addr),
        .cmd    (req_cmd),
        .tag    (req_tag),
        .eop    (req_eop),
        .contig (req_contig),
        .rdata  (mem_rdata),
        .wr_en  (wr_en),
        .reply  (next_reply)
    );

    pkt_mem_array #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .wr_en (wr_en),
        .idx   (req_addr[IDX_W-1:0]),
        .wdata (req_wdata),
        .rdata (mem_rdata)
    );

    pkt_reply_skid u_skid (
        .clk   (clk),
        .rst   (rst),
        .load  (fire),
        .din   (next_reply),
        .drain (rsp_ack),
        .full  (skid_full),
        .dout  (held_reply)
    );

    assign rsp_val    = skid_full;
    assign rsp_rdata  = held_reply.data;
    assign rsp_status = held_reply.status;
    assign rsp_tag    = held_reply.tag;
    assign rsp_eop    = held_reply.eop;

    // R2
    reply_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> rsp_val);
    // R2
    tag_echo_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (rsp_tag == $past(req_tag)));
    // R7
    eop_echo_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (rsp_eop == $past(req_eop)));
    // R4
    nop_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && (req_cmd == 2'b00 || req_cmd == 2'b11)) |=>
        (rsp_status == 2'b00 && rsp_rdata == '0));
endmodule

// File: tb/sim_pkt_mem_target.sv
module sim_pkt_mem_target;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_val;
    logic        req_ack;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic [1:0]  req_cmd;
    logic [3:0]  req_tag;
    logic        req_eop;
    logic        req_contig;
    logic        rsp_val;
    logic        rsp_ack;
    logic [31:0] rsp_rdata;
    logic [1:0]  rsp_status;
    logic [3:0]  rsp_tag;
    logic        rsp_eop;

    always #2 clk = !clk;

    pkt_mem_target u0 (
        .clk(clk), .rst(rst),
        .req_val(req_val), .req_ack(req_ack), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_cmd(req_cmd), .req_tag(req_tag),
        .req_eop(req_eop), .req_contig(req_contig),
        .rsp_val(rsp_val), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .rsp_status(rsp_status), .rsp_tag(rsp_tag), .rsp_eop(rsp_eop)
    );

    typedef struct packed {
        logic [31:0] data;
        logic [1:0]  status;
        logic [3:0]  tag;
        logic        eop;
    } exp_t;

    int          n_chk = 0;
    int          n_err = 0;
    exp_t        exp_q[$];
    string       rq_q[$];
    logic [31:0] ref_mem [64];
    logic [7:0]  ref_prev = 8'd0;
    logic        ref_mid  = 1'b0;
    logic        acc;

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] a, input logic [31:0] d,
                        input logic [1:0] c, input logic [3:0] t, input logic e,
                        input logic cg, input logic ra, output logic accepted);
        exp_t  x;
        logic  bad;
        string rq;
        @(negedge clk);
        chk(rsp_val == (exp_q.size() != 0), "R8", "rsp_val",
            64'(rsp_val), 64'(exp_q.size() != 0));
        if (exp_q.size() != 0 && rsp_val) begin
            x = exp_q[0];
            chk(rsp_rdata == x.data && rsp_status == x.status, rq_q[0], "data/status",
                {30'd0, rsp_status, rsp_rdata}, {30'd0, x.status, x.data});
            chk(rsp_tag == x.tag, "R2", "tag", 64'(rsp_tag), 64'(x.tag));
            chk(rsp_eop == x.eop, "R7", "eop", 64'(rsp_eop), 64'(x.eop));
        end
        req_val = v; req_addr = a; req_wdata = d; req_cmd = c;
        req_tag = t; req_eop = e; req_contig = cg; rsp_ack = ra;
        #1;
        chk(req_ack == ((exp_q.size() == 0) || ra), "R8", "req_ack",
            64'(req_ack), 64'((exp_q.size() == 0) || ra));
        if (ra && exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            void'(rq_q.pop_front());
        end
        accepted = v && req_ack;
        if (accepted) begin
            bad = (a >= 8'd64) || (cg && ref_mid && a != ref_prev + 8'd1);
            x.data = '0; x.status = 2'b00; x.tag = t; x.eop = e;
            if (c == 2'b00 || c == 2'b11) rq = "R4";
            else if (a >= 8'd64)          rq = "R5";
            else if (bad)                 rq = "R6";
            else if (c == 2'b01)          rq = "R2";
            else                          rq = "R3";
            if (c == 2'b01) begin
                if (bad) x.status = 2'b01;
                else     x.data   = ref_mem[a[5:0]];
            end else if (c == 2'b10) begin
                if (bad) x.status = 2'b01;
                else     ref_mem[a[5:0]] = d;
            end
            exp_q.push_back(x);
            rq_q.push_back(rq);
            ref_prev = a;
            ref_mid  = !e;
        end
    endtask

    task automatic send(input logic [7:0] a, input logic [31:0] d, input logic [1:0] c,
                        input logic [3:0] t, input logic e, input logic cg);
        logic ok;
        step(1'b1, a, d, c, t, e, cg, 1'b1, ok);
        // R9: with the reply side free every word is taken
        chk(ok, "R9", "accept", 64'(ok), 64'd1);
    endtask

    task automatic idle(input int n);
        logic ok;
        for (int i = 0; i < n; i++) step(1'b0, 8'd0, 32'd0, 2'b00, 4'd0, 1'b1, 1'b0, 1'b1, ok);
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; req_val = 0; req_addr = 0; req_wdata = 0; req_cmd = 0;
        req_tag = 0; req_eop = 0; req_contig = 0; rsp_ack = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rsp_val == 1'b0, "R1", "rsp_val", 64'(rsp_val), 64'd0);
        chk(req_ack == 1'b1, "R1", "req_ack", 64'(req_ack), 64'd1);

        // R3: contiguous write burst over the whole memory
        for (int i = 0; i < 64; i++)
            send(8'(i), 32'hA500_0000 + 32'(i * 7), 2'b10, 4'(i), i == 63, 1'b1);
        // R2: contiguous read burst
        for (int i = 0; i < 8; i++)
            send(8'(i + 20), 32'd0, 2'b01, 4'(15 - i), i == 7, 1'b1);
        // R2: scattered single reads
        send(8'd63, 32'd0, 2'b01, 4'd3, 1'b1, 1'b0);
        send(8'd0,  32'd0, 2'b01, 4'd9, 1'b1, 1'b0);
        // R5: out-of-range read and aliasing write, then readback of index 8
        send(8'd70,  32'd0,          2'b01, 4'd1, 1'b1, 1'b0);
        send(8'd200, 32'hDEAD_BEEF,  2'b10, 4'd2, 1'b1, 1'b0);
        send(8'd8,   32'd0,          2'b01, 4'd4, 1'b1, 1'b0);
        // R6: broken contiguous sequence, suppressed write, then readback
        send(8'd10, 32'h1111_1111, 2'b10, 4'd5, 1'b0, 1'b1);
        send(8'd12, 32'h2222_2222, 2'b10, 4'd6, 1'b1, 1'b1);
        send(8'd12, 32'd0,         2'b01, 4'd7, 1'b1, 1'b0);
        // R4: no-op and unused code do not write
        send(8'd5, 32'hFFFF_0000, 2'b00, 4'd8, 1'b1, 1'b0);
        send(8'd5, 32'hFFFF_0001, 2'b11, 4'd8, 1'b1, 1'b0);
        send(8'd5, 32'd0,         2'b01, 4'd8, 1'b1, 1'b0);
        // R8: reply stall with a steady request stream
        for (int i = 0; i < 6; i++)
            step(1'b1, 8'(30 + i), 32'd0, 2'b01, 4'(i), 1'b1, 1'b0, 1'b0, acc);
        idle(2);
        // random mix
        for (int i = 0; i < 500; i++)
            step($urandom_range(0, 3) != 0, 8'($urandom_range(0, 80)), $urandom,
                 2'($urandom_range(0, 3)), 4'($urandom), 1'($urandom),
                 1'($urandom), $urandom_range(0, 3) != 0, acc);
        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule